// File: doc/BRIEF.md
# I2C Serial Clock Phase Timer

This block derives the serial-clock timing of an I2C master from the system clock. A packed 8-bit divider code selects a power-of-two prescale and an even multiplier. An 8-bit filter-rate value sets how often the input glitch filter samples the bus lines. The filter rate also feeds a correction term into the divide ratio. The block splits each serial-clock period into a high phase and a low phase of equal length. It pulses a strobe at every phase boundary, which tells the byte engine when to move the clock and data lines.

A second output pulses once per filter period. That pulse clocks a three-sample majority-free glitch filter on the incoming clock and data lines. The filter passes a new level only after three samples in a row agree. The code and the rate may only be changed while the run input is low. Driving run low also puts every counter back to its idle state.

Top module: `i2c_scl_timer`

## Requirements
- R1: With run high and the rate value d (taken as 1 when zero), the strobe `phase_stb_o` pulses once every H cycles, where H is half of the divide ratio N. N is (A + 2·floor(3·d / P))·P, with P = 16 << fdr_i[4:2].
- R2: The multiplier A is selected by the 3-bit value {fdr_i[5], fdr_i[1:0]} as follows: 0→18, 1→20, 2→24, 3→30, 4→10, 5→12, 6→14, 7→16. Bits 7:6 of fdr_i are ignored.
- R3: A rate value of 0 gives exactly the same timing as a value of 1, both for the divide ratio and for `sample_en_o`.
- R4: After run rises, the first strobe appears on the H-th rising clock edge. `scl_phase_o` (1 = high phase) is 1 before it and inverts on every strobe.
- R5: While run is low, `phase_stb_o` and `sample_en_o` stay 0 and `scl_phase_o` stays 1.
- R6: With run high, `sample_en_o` pulses once every d cycles, and it stays high continuously when d is 1.
- R7: A filtered output takes a new level only after three consecutive sample pulses have seen that level. A level held for only 2·d cycles is ignored. A filtered output changes only in the cycle after a sample pulse.
- R8: After reset both filtered outputs are 1, and the raw inputs pass through a two-flop synchronizer before the filter.
- R9: The correction term uses the effective rate. For example, code 0x20 with rate 40 gives N = 384, while the same code with rate 1 gives N = 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Controller enable; code and rate change only while low |
| fdr_i | input | 8 | Packed divider code |
| dfsr_i | input | 8 | Filter sampling rate in system clocks |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| phase_stb_o | output | 1 | One-cycle pulse at each clock phase boundary |
| scl_phase_o | output | 1 | Current phase, 1 = high |
| sample_en_o | output | 1 | Filter sampling pulse |
| scl_filt_o | output | 1 | Filtered serial clock |
| sda_filt_o | output | 1 | Filtered serial data |

## Verification
The hardest case to reach is a glitch on a bus line that lasts almost long enough to pass the filter. The sample pulses are internal, so their alignment to the glitch cannot be controlled directly. The bench therefore uses a glitch width of exactly two rate periods. For any alignment, that width covers no more than two sample points. The bench then checks that the filtered line holds its level on every cycle. The correction term only shows up when the rate value is large compared with the prescale. The bench pairs the same code with a large rate and with a rate of one to expose it.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
   localparam int CODE_W  = 8;
   localparam int RATE_W  = 8;
   localparam int DIV_W   = 16;
   localparam int PRE_LOG = 4;

   function automatic logic [4:0] mult_of_sel(input logic [2:0] sel);
      logic [4:0] m;
      case (sel)
         3'd0: m = 5'd18;
         3'd1: m = 5'd20;
         3'd2: m = 5'd24;
         3'd3: m = 5'd30;
         3'd4: m = 5'd10;
         3'd5: m = 5'd12;
         3'd6: m = 5'd14;
         default: m = 5'd16;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/sclt_ratio.sv
module sclt_ratio
   import sclt_pkg::*;
#(
   parameter int DW = DIV_W,
   parameter int RW = RATE_W
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [RW-1:0]     rate_i,
   output logic [RW-1:0]     rate_eff_o,
   output logic [DW-1:0]     half_o
);
   localparam int PW = RW + 2;

   initial begin
      if (DW < 16) $error("sclt_ratio: DW must be at least 16");
   end

   logic [2:0]    exp_w;
   logic [2:0]    sel_w;
   logic [4:0]    mult_w;
   logic [PW-1:0] tri_rate;
   logic [PW-1:0] corr_w;
   logic [DW-1:0] base_w;
   logic [DW-1:0] ratio_w;

   always_comb begin
      exp_w      = code_i[4:2];
      sel_w      = {code_i[5], code_i[1:0]};
      mult_w     = mult_of_sel(sel_w);
      rate_eff_o = (rate_i == '0) ? RW'(1) : rate_i;
      tri_rate   = PW'(rate_eff_o) * PW'(3);
      corr_w     = tri_rate >> (PRE_LOG + int'(exp_w));
      base_w     = DW'(mult_w) + (DW'(corr_w) << 1);
      ratio_w    = base_w << (PRE_LOG + int'(exp_w));
      half_o     = ratio_w >> 1;
   end
endmodule

// File: rtl/sclt_phase.sv
module sclt_phase #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [DW-1:0] half_i,
   output logic          stb_o,
   output logic          phase_o
);
   logic [DW-1:0] cnt_q;
   logic          wrap_w;

   assign wrap_w = (cnt_q >= half_i - DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stb_o   <= 1'b0;
         phase_o <= 1'b1;
      end else if (!run_i) begin
         cnt_q   <= '0;
         stb_o   <= 1'b0;
         phase_o <= 1'b1;
      end else if (wrap_w) begin
         cnt_q   <= '0;
         stb_o   <= 1'b1;
         phase_o <= ~phase_o;
      end else begin
         cnt_q   <= cnt_q + DW'(1);
         stb_o   <= 1'b0;
      end
   end
endmodule

// File: rtl/sclt_tick.sv
module sclt_tick #(
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [RW-1:0] rate_i,
   output logic          tick_o
);
   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (cnt_q >= rate_i - RW'(1)) begin
         cnt_q  <= '0;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + RW'(1);
         tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sclt_filter.sv
module sclt_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int TAPS        = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic line_i,
   output logic line_o
);
   initial begin
      if (SYNC_STAGES < 1) $error("sclt_filter: SYNC_STAGES must be at least 1");
      if (TAPS < 2) $error("sclt_filter: TAPS must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [TAPS-1:0]        tap_q;
   logic [TAPS-1:0]        tap_n;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= line_i;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         end
      end
   endgenerate

   assign tap_n = {tap_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q  <= '1;
         line_o <= 1'b1;
      end else if (tick_i) begin
         tap_q <= tap_n;
         if (&tap_n)       line_o <= 1'b1;
         else if (~|tap_n) line_o <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import sclt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3,
   parameter int NUM_LINES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [CODE_W-1:0] fdr_i,
   input  logic [RATE_W-1:0] dfsr_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              phase_stb_o,
   output logic              scl_phase_o,
   output logic              sample_en_o,
   output logic              scl_filt_o,
   output logic              sda_filt_o
);
   initial begin
      if (NUM_LINES != 2) $error("i2c_scl_timer: NUM_LINES must be 2");
   end

   logic [DIV_W-1:0]     half_w;
   logic [RATE_W-1:0]    rate_eff_w;
   logic [NUM_LINES-1:0] raw_w;
   logic [NUM_LINES-1:0] filt_w;

   sclt_ratio #(.DW(DIV_W), .RW(RATE_W)) u_ratio (
      .code_i(fdr_i), .rate_i(dfsr_i),
      .rate_eff_o(rate_eff_w), .half_o(half_w)
   );

   sclt_phase #(.DW(DIV_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .half_i(half_w),
      .stb_o(phase_stb_o), .phase_o(scl_phase_o)
   );

   sclt_tick #(.RW(RATE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .rate_i(rate_eff_w),
      .tick_o(sample_en_o)
   );

   assign raw_w = {sda_i, scl_i};

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      sclt_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
         .clk(clk), .rst_n(rst_n), .tick_i(sample_en_o),
         .line_i(raw_w[g]), .line_o(filt_w[g])
      );
   end

   assign scl_filt_o = filt_w[0];
   assign sda_filt_o = filt_w[1];
endmodule

// File: rtl/sclt_checker.sv
module sclt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       run_i,
   input logic [7:0] dfsr_i,
   input logic       phase_stb_o,
   input logic       scl_phase_o,
   input logic       sample_en_o,
   input logic       scl_filt_o,
   input logic       sda_filt_o
);
   AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!phase_stb_o && !sample_en_o && scl_phase_o)); // R5
   AST_STB_FLIPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_stb_o |-> (scl_phase_o != $past(scl_phase_o))); // R4
   AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && !phase_stb_o) |-> $stable(scl_phase_o)); // R4
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_stb_o |=> !phase_stb_o); // R1
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en_o && dfsr_i > 8'd1 && run_i) |=> !sample_en_o); // R6
   AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_en_o) |-> ($stable(scl_filt_o) && $stable(sda_filt_o))); // R7
endmodule

bind i2c_scl_timer sclt_checker u_sclt_checker (
   .clk(clk), .rst_n(rst_n), .run_i(run_i), .dfsr_i(dfsr_i),
   .phase_stb_o(phase_stb_o), .scl_phase_o(scl_phase_o),
   .sample_en_o(sample_en_o), .scl_filt_o(scl_filt_o), .sda_filt_o(sda_filt_o)
);

// File: tb/test_i2c_scl_timer.sv
module test_i2c_scl_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_i = 1'b0;
   logic [7:0] fdr_i = 8'h00;
   logic [7:0] dfsr_i = 8'd1;
   logic       scl_i = 1'b1;
   logic       sda_i = 1'b1;
   logic       phase_stb_o, scl_phase_o, sample_en_o, scl_filt_o, sda_filt_o;

   int n_tests = 0;
   int n_fail  = 0;
   localparam int LIMIT = 20000;

   always #2ns clk = ~clk;

   i2c_scl_timer i_i2c_scl_timer (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .fdr_i(fdr_i), .dfsr_i(dfsr_i),
      .scl_i(scl_i), .sda_i(sda_i), .phase_stb_o(phase_stb_o),
      .scl_phase_o(scl_phase_o), .sample_en_o(sample_en_o),
      .scl_filt_o(scl_filt_o), .sda_filt_o(sda_filt_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mult_ref(input int sel);
      case (sel)
         0: return 18; 1: return 20; 2: return 24; 3: return 30;
         4: return 10; 5: return 12; 6: return 14; default: return 16;
      endcase
   endfunction

   function automatic int half_ref(input int code, input int rate);
      int d, p, a;
      d = (rate == 0) ? 1 : rate;
      p = 16 << ((code >> 2) & 7);
      a = mult_ref((((code >> 5) & 1) << 2) | (code & 3));
      return ((a + 2 * ((3 * d) / p)) * p) / 2;
   endfunction

   task automatic set_idle(input int code, input int rate);
      @(negedge clk);
      run_i  = 1'b0;
      fdr_i  = 8'(code);
      dfsr_i = 8'(rate);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_stb(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!phase_stb_o && n < LIMIT);
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_en_o && n < LIMIT);
   endtask

   // R1 R2 R4: first strobe latency, period, phase inversion
   task automatic t_ratio(input string req, input int code, input int rate);
      int first, gap, h;
      h = half_ref(code, rate);
      set_idle(code, rate);
      run_i = 1'b1;
      wait_stb(first);
      check({req, " R4 first strobe"}, first, h);
      check({req, " R4 phase after 1st"}, int'(scl_phase_o), 0);
      wait_stb(gap);
      check({req, " R1 period"}, gap, h);
      check({req, " R4 phase after 2nd"}, int'(scl_phase_o), 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R5 reset stb", int'(phase_stb_o), 0);
      check("R5 reset phase", int'(scl_phase_o), 1);
      check("R5 reset tick", int'(sample_en_o), 0);
      check("R8 reset scl filt", int'(scl_filt_o), 1);
      check("R8 reset sda filt", int'(sda_filt_o), 1);
   endtask

   task automatic t_idle();
      int seen;
      set_idle(8'h00, 1);
      seen = 0;
      repeat (400) begin
         @(negedge clk);
         if (phase_stb_o || sample_en_o || !scl_phase_o) seen++;
      end
      check("R5 idle activity", seen, 0);
   endtask

   task automatic t_tick(input string req, input int rate, input int expect_gap);
      int n, hi;
      set_idle(8'h00, rate);
      run_i = 1'b1;
      wait_tick(n);
      wait_tick(n);
      check({req, " tick gap"}, n, expect_gap);
      hi = 0;
      repeat (20) begin
         @(negedge clk);
         if (sample_en_o) hi++;
      end
      check({req, " ticks in 20"}, hi, 20 / expect_gap);
   endtask

   task automatic t_filter_glitch();
      int moved;
      set_idle(8'h00, 4);
      run_i = 1'b1;
      repeat (30) @(negedge clk);
      moved = 0;
      scl_i = 1'b0;
      sda_i = 1'b0;
      repeat (8) begin
         @(negedge clk);
         if (!scl_filt_o || !sda_filt_o) moved++;
      end
      scl_i = 1'b1;
      sda_i = 1'b1;
      repeat (30) begin
         @(negedge clk);
         if (!scl_filt_o || !sda_filt_o) moved++;
      end
      check("R7 short glitch ignored", moved, 0);
   endtask

   task automatic t_filter_accept();
      set_idle(8'h00, 4);
      run_i = 1'b1;
      repeat (10) @(negedge clk);
      scl_i = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 scl accepted low", int'(scl_filt_o), 0);
      check("R7 sda unaffected", int'(sda_filt_o), 1);
      sda_i = 1'b0;
      scl_i = 1'b1;
      repeat (20) @(negedge clk);
      check("R7 scl back high", int'(scl_filt_o), 1);
      check("R7 sda accepted low", int'(sda_filt_o), 0);
      sda_i = 1'b1;
      repeat (20) @(negedge clk);
      check("R8 sda back high", int'(sda_filt_o), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_ratio("R2 sel0", 8'h00, 1);
      t_ratio("R2 sel7", 8'h23, 1);
      t_ratio("R2 sel4 ignore b7:6", 8'hE0, 1);
      t_ratio("R1 exp2 sel2", 8'h0A, 1);
      t_ratio("R9 corr rate40", 8'h20, 40);
      t_ratio("R3 rate0", 8'h20, 0);
      check("R9 table 0x20/40", half_ref(8'h20, 40) * 2, 384);
      check("R9 table 0x20/1", half_ref(8'h20, 1) * 2, 160);
      t_tick("R6 rate5", 5, 5);
      t_tick("R3 rate0", 0, 1);
      t_tick("R6 rate1", 1, 1);
      t_filter_glitch();
      t_filter_accept();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule